// File: doc/BRIEF.md
# Timer Control Register Access Permission Checker

This block decides what happens to a system-register instruction that names one of two timer control registers. It receives the instruction encoding fields, the transfer direction, the exception level the instruction runs at, and the configuration bits that govern timer access: the security state, the hypervisor host-mode and trap-general bits, three nested-virtualisation bits, whether the second-stage level is enabled, whether the kernel or hypervisor level runs in its 32-bit execution state, and four access-enable bits. From these it produces one verdict: not handled, undefined, trap (with target level and exception class), access to a named physical control register, or redirect to a fixed memory slot. Carrying out the transfer or taking the exception is left to the logic that consumes the verdict.

The evaluation is a prioritised chain of conditions per exception level. One encoding can reach three different physical registers or a memory slot, depending on host mode and security state. The verdict is registered. A small two-state machine presents it: `ST_IDLE` (no verdict shown) moves to `ST_REPORT` when a request strobe arrives. `ST_REPORT` stays in `ST_REPORT` on a back-to-back strobe and returns to `ST_IDLE` when no strobe arrives. The verdict is visible only in `ST_REPORT`, which lasts one cycle per request.

Top module: `timer_ctl_access_gate`

## Requirements
- R1: After reset, and in every cycle not directly after a request strobe, `rsp_valid` is 0 and every verdict output is 0; a strobe in cycle N gives `rsp_valid`=1 with that request's verdict in cycle N+1 only.
- R2: A request is decoded only when op0=3, CRn=14, CRm=2 and op2=1, with op1=4 naming the secure hypervisor timer control and op1=3 naming the user physical timer control. Any other encoding gives kind 0 (not handled). Kind codes: 0 not handled, 1 access, 2 undefined, 3 trap, 4 memory redirect. Register selects: 0 secure hypervisor timer control, 1 non-secure hypervisor timer control, 2 user physical timer control. A trap carries a target level and class 0x18, and any other kind has both at 0. The register select is 0 unless the kind is access. The offset is 0 unless the kind is redirect.
- R3: Secure hypervisor encoding: at level 0 the verdict is undefined. At level 1 it is a trap to level 2 only when level 2 is enabled, the nested-virtualisation bit is 1 and the state is secure; every other level-1 case is undefined.
- R4: Secure hypervisor encoding: at level 2 the verdict is access to select 0 in secure state and undefined in non-secure state. At level 3 it is always access to select 0.
- R5: User encoding at level 0, first check: the kernel's user-timer enable is 0, level 1 is not 32-bit, and host mode (host bit and trap-general both 1, with level 2 enabled) is not active. The verdict is then a trap, to level 2 when level 2 is enabled in 64-bit state with trap-general 1, and to level 1 otherwise.
- R6: User encoding at level 0, when the first check does not fire and level 2 is enabled and 64-bit, these checks apply in order, each a trap to level 2. First, host bit 0 with the hypervisor's kernel counter enable 0. Second, host bit 1 with trap-general 0 and the hypervisor's kernel timer enable 0. Third, host bit 1 with trap-general 1 and the hypervisor's user timer enable 0.
- R7: User encoding at level 0 with no trap: in host mode with level 2 enabled and 64-bit, access goes to select 0 when secure and select 1 when non-secure. Otherwise access goes to select 2.
- R8: User encoding at level 1, with level 2 enabled and 64-bit, the verdict is a trap to level 2 in two cases: host bit 0 with the kernel counter enable 0, or host bit 1 with the kernel timer enable 0.
- R9: User encoding at level 1 with no trap: when level 2 is enabled and 64-bit and all three nested-virtualisation bits are 1, the verdict is a redirect to offset 0x180. Otherwise it is access to select 2.
- R10: User encoding at level 2: with host bit 1 the verdict is access to select 0 when secure or select 1 when non-secure. With host bit 0 it is access to select 2.
- R11: User encoding at level 3 always gives access to select 2; no level-3 request ever gives undefined or trap.
- R12: The transfer direction has no effect on the verdict and is echoed on `rsp_write` with the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_el | input | 2 | Current exception level |
| cfg_nonsecure | input | 1 | 1 = non-secure state |
| cfg_host_mode | input | 1 | Hypervisor host-mode bit |
| cfg_trap_general | input | 1 | Hypervisor trap-general bit |
| cfg_nest_virt | input | 1 | Nested-virtualisation bit |
| cfg_nest_v1 | input | 1 | Nested-virtualisation bit 1 |
| cfg_nest_v2 | input | 1 | Nested-virtualisation bit 2 |
| cfg_el2_on | input | 1 | Level 2 enabled |
| cfg_el1_is32 | input | 1 | Level 1 uses the 32-bit execution state |
| cfg_el2_is32 | input | 1 | Level 2 uses the 32-bit execution state |
| cfg_kern_user_tmr_en | input | 1 | Kernel control: user access to physical timer |
| cfg_hyp_kern_cnt_en | input | 1 | Hypervisor control: kernel counter access |
| cfg_hyp_kern_tmr_en | input | 1 | Hypervisor control: kernel timer access |
| cfg_hyp_user_tmr_en | input | 1 | Hypervisor control: user timer access in host mode |
| rsp_valid | output | 1 | Verdict valid pulse |
| rsp_kind | output | 3 | Verdict kind |
| rsp_tgt_el | output | 2 | Trap target level |
| rsp_class | output | 6 | Trap exception class |
| rsp_reg | output | 2 | Register select |
| rsp_mem_ofs | output | 12 | Redirect memory offset |
| rsp_write | output | 1 | Echoed direction |

## Verification
The bench sweeps every combination of level, security, host and trap-general bits, nested bits, level-2 state, execution-state flags and the four enables, for both encodings, plus a set of near-miss encodings. The sweep targets the ordering of the user-encoding checks at level 0:
- A design that tested the kernel enable after the hypervisor enables would pick the wrong trap target.
- A design that ignored the host-mode exclusion would trap level-0 host accesses to level 1.
- Dropping the 64-bit qualifier would trap or redirect when level 2 runs 32-bit.
- Confusing the security sense would send host-mode accesses to the wrong hypervisor register.
- A decoder that treated near-miss encodings as undefined would claim instructions that belong to other decoders.

// File: rtl/tca_pkg.sv
package tca_pkg;

    localparam int EL_W   = 2;
    localparam int SEL_W  = 2;
    localparam int KIND_W = 3;

    localparam logic [EL_W-1:0] EL_USER = 2'd0;
    localparam logic [EL_W-1:0] EL_KERN = 2'd1;
    localparam logic [EL_W-1:0] EL_HYP  = 2'd2;
    localparam logic [EL_W-1:0] EL_MON  = 2'd3;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE     = 3'd0,
        KIND_ACCESS   = 3'd1,
        KIND_UNDEF    = 3'd2,
        KIND_TRAP     = 3'd3,
        KIND_MEMREDIR = 3'd4
    } kind_e;

    typedef enum logic [SEL_W-1:0] {
        REG_SEC_HYP   = 2'd0,
        REG_NS_HYP    = 2'd1,
        REG_USER_PHYS = 2'd2
    } reg_e;

    typedef struct packed {
        logic nonsecure;
        logic host;
        logic tgen;
        logic nv;
        logic nv1;
        logic nv2;
        logic el2_on;
        logic el1_is32;
        logic el2_is32;
        logic kern_user_tmr_en;
        logic hyp_kern_cnt_en;
        logic hyp_kern_tmr_en;
        logic hyp_user_tmr_en;
    } cfg_t;

    typedef struct packed {
        kind_e           kind;
        logic [EL_W-1:0] tgt_el;
        reg_e            sel;
    } verdict_t;

endpackage

// File: rtl/tca_enc_match.sv
module tca_enc_match #(
    parameter logic [1:0] OP0_VAL      = 2'd3,
    parameter logic [3:0] CRN_VAL      = 4'd14,
    parameter logic [3:0] CRM_VAL      = 4'd2,
    parameter logic [2:0] OP2_VAL      = 3'd1,
    parameter logic [2:0] OP1_SEC_HYP  = 3'd4,
    parameter logic [2:0] OP1_USER     = 3'd3
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit_sec_hyp,
    output logic       hit_user
);
    logic common_ok;

    assign common_ok   = (op0 == OP0_VAL) && (crn == CRN_VAL) &&
                         (crm == CRM_VAL) && (op2 == OP2_VAL);
    assign hit_sec_hyp = common_ok && (op1 == OP1_SEC_HYP);
    assign hit_user    = common_ok && (op1 == OP1_USER);
endmodule

// File: rtl/tca_rules.sv
module tca_rules
    import tca_pkg::*;
(
    input  logic            hit_sec_hyp,
    input  logic            hit_user,
    input  logic [EL_W-1:0] el,
    input  cfg_t            cfg,
    output verdict_t        verdict
);
    logic hyp64;       // level 2 enabled and 64-bit
    logic host_user;   // host bit and trap-general both set
    logic gate_kern;   // first level-0 check

    assign hyp64     = cfg.el2_on && !cfg.el2_is32;
    assign host_user = cfg.host && cfg.tgen;
    assign gate_kern = !cfg.el1_is32 && !(cfg.el2_on && host_user) &&
                       !cfg.kern_user_tmr_en;

    always_comb begin
        verdict.kind   = KIND_NONE;
        verdict.tgt_el = EL_USER;
        verdict.sel    = REG_SEC_HYP;
        if (hit_sec_hyp) begin
            unique case (el)
                EL_USER: verdict.kind = KIND_UNDEF;
                EL_KERN: begin
                    if (cfg.el2_on && cfg.nv && !cfg.nonsecure) begin
                        verdict.kind   = KIND_TRAP;
                        verdict.tgt_el = EL_HYP;
                    end else begin
                        verdict.kind = KIND_UNDEF;
                    end
                end
                EL_HYP: begin
                    if (!cfg.nonsecure) verdict.kind = KIND_ACCESS;
                    else                verdict.kind = KIND_UNDEF;
                end
                default: verdict.kind = KIND_ACCESS;
            endcase
        end else if (hit_user) begin
            unique case (el)
                EL_USER: begin
                    if (gate_kern) begin
                        verdict.kind   = KIND_TRAP;
                        verdict.tgt_el = (hyp64 && cfg.tgen) ? EL_HYP : EL_KERN;
                    end else if (hyp64 && !cfg.host && !cfg.hyp_kern_cnt_en) begin
                        verdict.kind   = KIND_TRAP;
                        verdict.tgt_el = EL_HYP;
                    end else if (hyp64 && cfg.host && !cfg.tgen && !cfg.hyp_kern_tmr_en) begin
                        verdict.kind   = KIND_TRAP;
                        verdict.tgt_el = EL_HYP;
                    end else if (hyp64 && host_user && !cfg.hyp_user_tmr_en) begin
                        verdict.kind   = KIND_TRAP;
                        verdict.tgt_el = EL_HYP;
                    end else if (hyp64 && host_user) begin
                        verdict.kind = KIND_ACCESS;
                        verdict.sel  = cfg.nonsecure ? REG_NS_HYP : REG_SEC_HYP;
                    end else begin
                        verdict.kind = KIND_ACCESS;
                        verdict.sel  = REG_USER_PHYS;
                    end
                end
                EL_KERN: begin
                    if (hyp64 && !cfg.host && !cfg.hyp_kern_cnt_en) begin
                        verdict.kind   = KIND_TRAP;
                        verdict.tgt_el = EL_HYP;
                    end else if (hyp64 && cfg.host && !cfg.hyp_kern_tmr_en) begin
                        verdict.kind   = KIND_TRAP;
                        verdict.tgt_el = EL_HYP;
                    end else if (hyp64 && cfg.nv2 && cfg.nv1 && cfg.nv) begin
                        verdict.kind = KIND_MEMREDIR;
                    end else begin
                        verdict.kind = KIND_ACCESS;
                        verdict.sel  = REG_USER_PHYS;
                    end
                end
                EL_HYP: begin
                    verdict.kind = KIND_ACCESS;
                    if (cfg.host) verdict.sel = cfg.nonsecure ? REG_NS_HYP : REG_SEC_HYP;
                    else          verdict.sel = REG_USER_PHYS;
                end
                default: begin
                    verdict.kind = KIND_ACCESS;
                    verdict.sel  = REG_USER_PHYS;
                end
            endcase
        end
    end
endmodule

// File: rtl/timer_ctl_access_gate.sv
module timer_ctl_access_gate
    import tca_pkg::*;
#(
    parameter int          CLASS_W    = 6,
    parameter int          OFS_W      = 12,
    parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
    parameter logic [OFS_W-1:0]   MEM_SLOT   = 12'h180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_op0,
    input  logic [2:0]         req_op1,
    input  logic [3:0]         req_crn,
    input  logic [3:0]         req_crm,
    input  logic [2:0]         req_op2,
    input  logic [1:0]         req_el,
    input  logic               cfg_nonsecure,
    input  logic               cfg_host_mode,
    input  logic               cfg_trap_general,
    input  logic               cfg_nest_virt,
    input  logic               cfg_nest_v1,
    input  logic               cfg_nest_v2,
    input  logic               cfg_el2_on,
    input  logic               cfg_el1_is32,
    input  logic               cfg_el2_is32,
    input  logic               cfg_kern_user_tmr_en,
    input  logic               cfg_hyp_kern_cnt_en,
    input  logic               cfg_hyp_kern_tmr_en,
    input  logic               cfg_hyp_user_tmr_en,
    output logic               rsp_valid,
    output logic [2:0]         rsp_kind,
    output logic [1:0]         rsp_tgt_el,
    output logic [CLASS_W-1:0] rsp_class,
    output logic [1:0]         rsp_reg,
    output logic [OFS_W-1:0]   rsp_mem_ofs,
    output logic               rsp_write
);
    typedef enum logic {ST_IDLE, ST_REPORT} state_e;

    state_e   state_q, state_d;
    verdict_t verdict_d, verdict_q;
    logic     write_q;
    logic     hit_sec_hyp, hit_user;
    cfg_t     cfg;

    assign cfg = '{
        nonsecure:        cfg_nonsecure,
        host:             cfg_host_mode,
        tgen:             cfg_trap_general,
        nv:               cfg_nest_virt,
        nv1:              cfg_nest_v1,
        nv2:              cfg_nest_v2,
        el2_on:           cfg_el2_on,
        el1_is32:         cfg_el1_is32,
        el2_is32:         cfg_el2_is32,
        kern_user_tmr_en: cfg_kern_user_tmr_en,
        hyp_kern_cnt_en:  cfg_hyp_kern_cnt_en,
        hyp_kern_tmr_en:  cfg_hyp_kern_tmr_en,
        hyp_user_tmr_en:  cfg_hyp_user_tmr_en
    };

    tca_enc_match u_match (
        .op0         (req_op0),
        .op1         (req_op1),
        .crn         (req_crn),
        .crm         (req_crm),
        .op2         (req_op2),
        .hit_sec_hyp (hit_sec_hyp),
        .hit_user    (hit_user)
    );

    tca_rules u_rules (
        .hit_sec_hyp (hit_sec_hyp),
        .hit_user    (hit_user),
        .el          (req_el),
        .cfg         (cfg),
        .verdict     (verdict_d)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and verdict capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= '{kind: KIND_NONE, tgt_el: EL_USER, sel: REG_SEC_HYP};
            write_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                verdict_q <= verdict_d;
                write_q   <= req_write;
            end
        end
    end

    // outputs
    always_comb begin
        rsp_valid   = 1'b0;
        rsp_kind    = KIND_NONE;
        rsp_tgt_el  = '0;
        rsp_class   = '0;
        rsp_reg     = '0;
        rsp_mem_ofs = '0;
        rsp_write   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REPORT: begin
                rsp_valid  = 1'b1;
                rsp_kind   = verdict_q.kind;
                rsp_write  = write_q;
                if (verdict_q.kind == KIND_TRAP) begin
                    rsp_tgt_el = verdict_q.tgt_el;
                    rsp_class  = TRAP_CLASS;
                end
                if (verdict_q.kind == KIND_ACCESS) rsp_reg = verdict_q.sel;
                if (verdict_q.kind == KIND_MEMREDIR) rsp_mem_ofs = MEM_SLOT;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/timer_ctl_access_gate_props.sv
module timer_ctl_access_gate_props (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_el,
    input logic        rsp_valid,
    input logic [2:0]  rsp_kind,
    input logic [1:0]  rsp_tgt_el,
    input logic [5:0]  rsp_class,
    input logic [1:0]  rsp_reg,
    input logic [11:0] rsp_mem_ofs,
    input logic        rsp_write
);
    assert_valid_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_quiet_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_kind == 3'd0 && rsp_reg == 2'd0));

    assert_trap_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd3) |-> (rsp_class == 6'h18 &&
                                             (rsp_tgt_el == 2'd1 || rsp_tgt_el == 2'd2)));

    assert_redirect_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd4) |-> (rsp_mem_ofs == 12'h180 && $past(req_el) == 2'd1));

    assert_monitor_never_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_el) == 2'd3) |-> (rsp_kind == 3'd0 || rsp_kind == 3'd1));

    assert_direction_echo_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_write == $past(req_write)));
endmodule

bind timer_ctl_access_gate timer_ctl_access_gate_props u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_el      (req_el),
    .rsp_valid   (rsp_valid),
    .rsp_kind    (rsp_kind),
    .rsp_tgt_el  (rsp_tgt_el),
    .rsp_class   (rsp_class),
    .rsp_reg     (rsp_reg),
    .rsp_mem_ofs (rsp_mem_ofs),
    .rsp_write   (rsp_write)
);

// File: tb/timer_ctl_access_gate_test.sv
module timer_ctl_access_gate_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_op0 = '0, req_el = '0;
    logic [2:0] req_op1 = '0, req_op2 = '0;
    logic [3:0] req_crn = '0, req_crm = '0;
    logic cfg_nonsecure = 0, cfg_host_mode = 0, cfg_trap_general = 0;
    logic cfg_nest_virt = 0, cfg_nest_v1 = 0, cfg_nest_v2 = 0;
    logic cfg_el2_on = 0, cfg_el1_is32 = 0, cfg_el2_is32 = 0;
    logic cfg_kern_user_tmr_en = 0, cfg_hyp_kern_cnt_en = 0;
    logic cfg_hyp_kern_tmr_en = 0, cfg_hyp_user_tmr_en = 0;
    logic        rsp_valid, rsp_write;
    logic [2:0]  rsp_kind;
    logic [1:0]  rsp_tgt_el, rsp_reg;
    logic [5:0]  rsp_class;
    logic [11:0] rsp_mem_ofs;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    timer_ctl_access_gate uut (.*);

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Expected verdict from the requirements. c bits: [1:0] level, 2 nonsecure,
    // 3 host, 4 trap-general, 5 nv, 6 nv1, 7 nv2, 8 level2 on, 9 lvl1 32-bit,
    // 10 lvl2 32-bit, 11 kern user en, 12 hyp kern cnt en, 13 hyp kern tmr en,
    // 14 hyp user tmr en.
    function automatic void predict(input bit sec_enc, input logic [14:0] c,
                                    output logic [2:0] k, output logic [1:0] t,
                                    output logic [1:0] s, output string tag);
        logic [1:0] lv = c[1:0];
        bit ns = c[2], h = c[3], g = c[4], n0 = c[5], n1 = c[6], n2 = c[7];
        bit on = c[8], k32 = c[9], h32 = c[10];
        bit kue = c[11], hkc = c[12], hkt = c[13], hut = c[14];
        bit h64 = on && !h32;
        k = 3'd1; t = 2'd0; s = 2'd2; tag = "R11";
        if (sec_enc) begin
            s = 2'd0;
            if (lv == 0) begin k = 3'd2; tag = "R3"; end
            else if (lv == 1) begin
                tag = "R3";
                if (on && n0 && !ns) begin k = 3'd3; t = 2'd2; end else k = 3'd2;
            end else if (lv == 2) begin
                tag = "R4";
                if (ns) k = 3'd2;
            end else tag = "R4";
            if (k != 3'd1) s = 2'd0;
        end else if (lv == 0) begin
            if (!k32 && !(on && h && g) && !kue) begin
                k = 3'd3; t = (h64 && g) ? 2'd2 : 2'd1; tag = "R5";
            end else if (h64 && ((!h && !hkc) || (h && !g && !hkt) || (h && g && !hut))) begin
                k = 3'd3; t = 2'd2; tag = "R6";
            end else begin
                tag = "R7";
                if (h64 && h && g) s = ns ? 2'd1 : 2'd0;
            end
        end else if (lv == 1) begin
            if (h64 && ((!h && !hkc) || (h && !hkt))) begin
                k = 3'd3; t = 2'd2; tag = "R8";
            end else if (h64 && n0 && n1 && n2) begin
                k = 3'd4; tag = "R9";
            end else tag = "R9";
        end else if (lv == 2) begin
            tag = "R10";
            if (h) s = ns ? 2'd1 : 2'd0;
        end
        if (k != 3'd1) s = 2'd0;
    endfunction

    task automatic issue(input logic [1:0] o0, input logic [2:0] o1, input logic [3:0] cn,
                         input logic [3:0] cm, input logic [2:0] o2,
                         input logic [14:0] c, input logic wr);
        req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2;
        req_el = c[1:0]; cfg_nonsecure = c[2]; cfg_host_mode = c[3];
        cfg_trap_general = c[4]; cfg_nest_virt = c[5]; cfg_nest_v1 = c[6];
        cfg_nest_v2 = c[7]; cfg_el2_on = c[8]; cfg_el1_is32 = c[9];
        cfg_el2_is32 = c[10]; cfg_kern_user_tmr_en = c[11];
        cfg_hyp_kern_cnt_en = c[12]; cfg_hyp_kern_tmr_en = c[13];
        cfg_hyp_user_tmr_en = c[14]; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic verify(input logic [2:0] k, input logic [1:0] t, input logic [1:0] s,
                          input string tag, input logic wr);
        logic [5:0]  ec  = (k == 3'd3) ? 6'h18 : 6'h00;
        logic [11:0] ofs = (k == 3'd4) ? 12'h180 : 12'h000;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_kind !== k || rsp_tgt_el !== t || rsp_reg !== s ||
            rsp_class !== ec || rsp_mem_ofs !== ofs) begin
            errors++;
            $display("FAIL %s: actual v=%0b kind=%0d tgt=%0d reg=%0d cls=%h ofs=%h, expected v=1 kind=%0d tgt=%0d reg=%0d cls=%h ofs=%h",
                     tag, rsp_valid, rsp_kind, rsp_tgt_el, rsp_reg, rsp_class, rsp_mem_ofs,
                     k, t, s, ec, ofs);
        end
        checks++;
        if (rsp_write !== wr) begin
            errors++;
            $display("FAIL R12: actual write=%0b, expected %0b", rsp_write, wr);
        end
    endtask

    task automatic check_idle(input string why);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_kind !== 3'd0 || rsp_reg !== 2'd0 ||
            rsp_class !== 6'd0 || rsp_mem_ofs !== 12'd0) begin
            errors++;
            $display("FAIL R1 (%s): actual v=%0b kind=%0d, expected v=0 kind=0",
                     why, rsp_valid, rsp_kind);
        end
    endtask

    initial begin
        logic [2:0] ek;
        logic [1:0] et, es;
        string tg;
        repeat (3) @(negedge clk);
        check_idle("reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");

        // Exhaustive sweep of both encodings (R2..R12)
        for (int enc = 0; enc < 2; enc++) begin
            for (int i = 0; i < 32768; i++) begin
                logic [14:0] c = i[14:0];
                logic wr = ^c ^ enc[0];
                issue(2'd3, enc ? 3'd4 : 3'd3, 4'd14, 4'd2, 3'd1, c, wr);
                predict(enc == 1, c, ek, et, es, tg);
                verify(ek, et, es, tg, wr);
            end
        end

        @(negedge clk);
        check_idle("no strobe");

        // Near-miss encodings are not handled (R2)
        for (int m = 0; m < 6; m++) begin
            for (int lv = 0; lv < 4; lv++) begin
                logic [14:0] c = {13'h0, lv[1:0]};
                logic wr = lv[0];
                case (m)
                    0: issue(2'd3, 3'd5, 4'd14, 4'd2, 3'd1, c, wr);
                    1: issue(2'd2, 3'd4, 4'd14, 4'd2, 3'd1, c, wr);
                    2: issue(2'd3, 3'd3, 4'd13, 4'd2, 3'd1, c, wr);
                    3: issue(2'd3, 3'd4, 4'd14, 4'd3, 3'd1, c, wr);
                    4: issue(2'd3, 3'd3, 4'd14, 4'd2, 3'd0, c, wr);
                    default: issue(2'd3, 3'd0, 4'd14, 4'd2, 3'd1, c, wr);
                endcase
                verify(3'd0, 2'd0, 2'd0, "R2", wr);
            end
        end

        @(negedge clk);
        check_idle("end");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule